// File: doc/BRIEF.md
# Dual-Channel Disk I/O Window Decoder

This block sits between a host I/O port and the register targets of a two-channel disk interface controller. Every I/O access is compared against five windows, each with its own programmable base and length: the command block and the control block of each channel, plus one shared window for the DMA-engine registers of both channels. The first matching window wins. The access is handed on with its window-local offset, the channel it belongs to and the device position (master or slave) that is currently selected on that channel.

The decoder keeps the master/slave selection of each channel itself, by watching writes to the drive-select location of that channel's command block. When the selected position is empty, it swallows command and control accesses and returns zero data. A global I/O enable gates every access, and a separate DMA-engine enable gates writes into the DMA window. Results leave a register stage one cycle after the request.

Top module: `ide_io_decoder`

## Requirements
- R1: Every cycle with `req_valid` high is followed, one cycle later, by a single-cycle `done` pulse. A cycle without a request produces no `done`, `fwd_valid` or error pulse.
- R2: Only sizes 1, 2 and 4 are legal. Any other `req_size` raises `err_size` with `done`, forwards nothing and leaves the channel selection unchanged.
- R3: While `io_en` is low, a legally sized access completes with `done` only. It forwards nothing, raises no error, changes no selection and reads zero.
- R4: The windows are tried in a fixed order, which is also their `fwd_region` code: primary command = 0, primary control = 1, secondary command = 2, secondary control = 3, DMA window = 4. An address hits a window when base <= address < base + length. An enabled, legally sized access that hits no window raises `err_map` and forwards nothing.
- R5: The primary command offset is (address - base) shifted right by `PRI_CMD_SHIFT`. The secondary command offset is address - base, with no shift.
- R6: The primary control offset is (address - base) + `PRI_CTRL_ADD`, truncated to `OW` bits. The secondary control offset is address - base.
- R7: In the DMA window, a local offset below `BM_CHAN_BYTES` goes to channel 0 unchanged. A higher offset goes to channel 1 with `BM_CHAN_BYTES` subtracted. `fwd_slave` is 0 for DMA-window accesses.
- R8: While `bm_en` is low, writes that hit the DMA window are dropped without error. Reads of the DMA window are still forwarded.
- R9: Each channel resets to master (`fwd_slave` = 0). A write to a channel's command block at offset `SEL_OFFSET` (6), after the R5 offset rule, selects the slave if data bit `SEL_BIT` (4) is 1 and the master otherwise. That write is itself routed to the newly selected position.
- R10: `dev_present` bit index = channel*2 + slave. A command or control access whose selected position is absent is not forwarded.
- R11: `rd_data` equals `tgt_rdata` in the `done` cycle of a forwarded read. Otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | Global I/O decode enable |
| bm_en | input | 1 | DMA-window write enable |
| dev_present | input | 4 | Device present per position, index channel*2+slave |
| rgn_base | input | 5 x AW | Base address of each window, indexed by region code |
| rgn_len | input | 5 x AW | Length in bytes of each window |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access size in bytes |
| req_addr | input | AW | I/O address |
| req_wdata | input | DW | Write data |
| tgt_rdata | input | DW | Read data from the addressed target, valid in the `done` cycle |
| done | output | 1 | Access completed |
| err_size | output | 1 | Illegal size |
| err_map | output | 1 | Address outside all windows |
| fwd_valid | output | 1 | Access forwarded to a target |
| fwd_region | output | 3 | Region code of the forwarded access |
| fwd_chan | output | 1 | Channel of the forwarded access |
| fwd_slave | output | 1 | Selected position (command/control only) |
| fwd_write | output | 1 | Forwarded direction |
| fwd_size | output | 3 | Forwarded size |
| fwd_offset | output | OW | Window-local offset |
| fwd_wdata | output | DW | Forwarded write data |
| rd_data | output | DW | Read data returned to the host |

## Verification
Two functions can act on the same access: a drive-select write updates the channel's selection, and the presence check looks at the position that was just selected. The bench provokes this by writing the select location with bit 4 set and cleared under all sixteen presence patterns. A write that moves the selection onto an empty position must be swallowed, while the selection still moves. Later reads of that channel's command and control blocks show the new position through `fwd_slave`, or through dropped forwarding. A second collision comes from overlapping windows, where one address hits two windows at once. The bench moves the secondary command base inside the primary command window and judges that the lower region code wins.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  localparam int NRGN = 5;
  localparam int RIW  = 3;

  typedef enum logic [RIW-1:0] {
    RG_PCMD = 3'd0,
    RG_PCTL = 3'd1,
    RG_SCMD = 3'd2,
    RG_SCTL = 3'd3,
    RG_DMA  = 3'd4
  } rgn_e;

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic logic rgn_is_dev(input logic [RIW-1:0] r);
    return r < RIW'(RG_DMA);
  endfunction

  function automatic logic rgn_is_cmd(input logic [RIW-1:0] r);
    return (r == RIW'(RG_PCMD)) || (r == RIW'(RG_SCMD));
  endfunction

  function automatic logic rgn_chan(input logic [RIW-1:0] r);
    return (r == RIW'(RG_SCMD)) || (r == RIW'(RG_SCTL));
  endfunction

endpackage

// File: rtl/ide_win_match.sv
module ide_win_match #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic          hit,
  output logic [AW-1:0] rel
);
  logic [AW:0] upper;

  always_comb begin
    upper = {1'b0, base} + {1'b0, len};
    hit   = (addr >= base) && ({1'b0, addr} < upper);
    rel   = addr - base;
  end
endmodule

// File: rtl/ide_first_hit.sv
module ide_first_hit #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  hits,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        idx = IW'(i);
      end
    end
    any = |hits;
  end

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~hits) == '0));

  assert_grant_any_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (grant != '0));
endmodule

// File: rtl/ide_sel_track.sv
module ide_sel_track (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic upd_val,
  output logic sel_q,
  output logic sel_nx
);
  assign sel_nx = upd ? upd_val : sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_nx;
  end

  assert_sel_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (sel_q == $past(upd_val)));

  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(sel_q));
endmodule

// File: rtl/ide_io_decoder.sv
module ide_io_decoder
  import ide_dec_pkg::*;
#(
  parameter int AW            = 16,
  parameter int OW            = 8,
  parameter int DW            = 32,
  parameter int PRI_CMD_SHIFT = 0,
  parameter int PRI_CTRL_ADD  = 0,
  parameter int BM_CHAN_BYTES = 8,
  parameter int SEL_OFFSET    = 6,
  parameter int SEL_BIT       = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     io_en,
  input  logic                     bm_en,
  input  logic [3:0]               dev_present,
  input  logic [NRGN-1:0][AW-1:0]  rgn_base,
  input  logic [NRGN-1:0][AW-1:0]  rgn_len,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [2:0]               req_size,
  input  logic [AW-1:0]            req_addr,
  input  logic [DW-1:0]            req_wdata,
  input  logic [DW-1:0]            tgt_rdata,
  output logic                     done,
  output logic                     err_size,
  output logic                     err_map,
  output logic                     fwd_valid,
  output logic [RIW-1:0]           fwd_region,
  output logic                     fwd_chan,
  output logic                     fwd_slave,
  output logic                     fwd_write,
  output logic [2:0]               fwd_size,
  output logic [OW-1:0]            fwd_offset,
  output logic [DW-1:0]            fwd_wdata,
  output logic [DW-1:0]            rd_data
);
  localparam logic [AW-1:0] CHB   = AW'(BM_CHAN_BYTES);
  localparam logic [AW-1:0] CADD  = AW'(PRI_CTRL_ADD);
  localparam logic [OW-1:0] SELO  = OW'(SEL_OFFSET);

  // window match, one per region
  logic [NRGN-1:0]         hits;
  logic [NRGN-1:0][AW-1:0] rel;

  for (genvar g = 0; g < NRGN; g++) begin : g_win
    ide_win_match #(.AW(AW)) u_win (
      .addr (req_addr),
      .base (rgn_base[g]),
      .len  (rgn_len[g]),
      .hit  (hits[g]),
      .rel  (rel[g])
    );
  end

  logic [NRGN-1:0] grant;
  logic [RIW-1:0]  idx;
  logic            any_hit;

  ide_first_hit #(.N(NRGN), .IW(RIW)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .hits  (hits),
    .grant (grant),
    .idx   (idx),
    .any   (any_hit)
  );

  // local offset per region
  logic [NRGN-1:0][AW-1:0] off_w;
  logic                    dma_hi;

  always_comb begin
    dma_hi        = rel[RG_DMA] >= CHB;
    off_w[RG_PCMD] = rel[RG_PCMD] >> PRI_CMD_SHIFT;
    off_w[RG_PCTL] = rel[RG_PCTL] + CADD;
    off_w[RG_SCMD] = rel[RG_SCMD];
    off_w[RG_SCTL] = rel[RG_SCTL];
    off_w[RG_DMA]  = dma_hi ? (rel[RG_DMA] - CHB) : rel[RG_DMA];
  end

  // named internal events
  logic          size_ok;
  logic          acc_live;
  logic          is_dev;
  logic          is_cmd;
  logic          chan_c;
  logic [AW-1:0] off_full;
  logic [OW-1:0] off_c;
  logic          sel_wr;
  logic [1:0]    sel_upd;
  logic [1:0]    sel_q;
  logic [1:0]    sel_nx;
  logic          slave_c;
  logic          dev_absent;
  logic          dma_wr_drop;
  logic          fwd_c;

  always_comb begin
    size_ok     = size_legal(req_size);
    acc_live    = req_valid && size_ok && io_en;
    is_dev      = rgn_is_dev(idx);
    is_cmd      = rgn_is_cmd(idx);
    chan_c      = is_dev ? rgn_chan(idx) : dma_hi;
    off_full    = off_w[idx];
    off_c       = off_full[OW-1:0];
    sel_wr      = acc_live && any_hit && req_write && is_cmd && (off_c == SELO);
    sel_upd[0]  = sel_wr && !chan_c;
    sel_upd[1]  = sel_wr && chan_c;
  end

  for (genvar c = 0; c < 2; c++) begin : g_sel
    ide_sel_track u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (sel_upd[c]),
      .upd_val (req_wdata[SEL_BIT]),
      .sel_q   (sel_q[c]),
      .sel_nx  (sel_nx[c])
    );
  end

  always_comb begin
    slave_c     = is_dev ? sel_nx[chan_c] : 1'b0;
    dev_absent  = is_dev && !dev_present[{chan_c, slave_c}];
    dma_wr_drop = !is_dev && req_write && !bm_en;
    fwd_c       = acc_live && any_hit && !dev_absent && !dma_wr_drop;
  end

  // result stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      err_size   <= 1'b0;
      err_map    <= 1'b0;
      fwd_valid  <= 1'b0;
      fwd_region <= '0;
      fwd_chan   <= 1'b0;
      fwd_slave  <= 1'b0;
      fwd_write  <= 1'b0;
      fwd_size   <= '0;
      fwd_offset <= '0;
      fwd_wdata  <= '0;
    end else begin
      done      <= req_valid;
      err_size  <= req_valid && !size_ok;
      err_map   <= acc_live && !any_hit;
      fwd_valid <= fwd_c;
      if (fwd_c) begin
        fwd_region <= idx;
        fwd_chan   <= chan_c;
        fwd_slave  <= slave_c;
        fwd_write  <= req_write;
        fwd_size   <= req_size;
        fwd_offset <= off_c;
        fwd_wdata  <= req_wdata;
      end
    end
  end

  assign rd_data = (fwd_valid && !fwd_write) ? tgt_rdata : '0;

  assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done && !fwd_valid && !err_size && !err_map);

  assert_bad_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !size_ok) |=> err_size && !fwd_valid);

  assert_io_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !io_en) |=> !fwd_valid && !err_map);

  assert_unmapped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_live && (hits == '0)) |=> err_map && !fwd_valid);

  assert_dma_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_live && grant[RG_DMA] && req_write && !bm_en) |=> !fwd_valid);

  assert_absent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_live && dev_absent) |=> !fwd_valid);

  assert_err_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_size && err_map) && !(fwd_valid && (err_size || err_map)));
endmodule

// File: tb/test_ide_io_decoder.sv
module test_ide_io_decoder;
  localparam int AW = 16, OW = 8, DW = 32;
  localparam int SH = 1, CADD = 2, CHB = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic io_en, bm_en;
  logic [3:0] dev_present;
  logic [4:0][AW-1:0] rgn_base, rgn_len;
  logic req_valid, req_write;
  logic [2:0] req_size;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, tgt_rdata;
  logic done, err_size, err_map, fwd_valid, fwd_chan, fwd_slave, fwd_write;
  logic [2:0] fwd_region, fwd_size;
  logic [OW-1:0] fwd_offset;
  logic [DW-1:0] fwd_wdata, rd_data;

  always #10 clk = ~clk;

  ide_io_decoder #(.AW(AW), .OW(OW), .DW(DW), .PRI_CMD_SHIFT(SH),
    .PRI_CTRL_ADD(CADD), .BM_CHAN_BYTES(CHB)) i_ide_io_decoder (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .bm_en(bm_en),
    .dev_present(dev_present), .rgn_base(rgn_base), .rgn_len(rgn_len),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .tgt_rdata(tgt_rdata),
    .done(done), .err_size(err_size), .err_map(err_map),
    .fwd_valid(fwd_valid), .fwd_region(fwd_region), .fwd_chan(fwd_chan),
    .fwd_slave(fwd_slave), .fwd_write(fwd_write), .fwd_size(fwd_size),
    .fwd_offset(fwd_offset), .fwd_wdata(fwd_wdata), .rd_data(rd_data));

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  bit msel [2];

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one access: drive at negedge, sample at the next negedge
  task automatic apply(input bit w, input int a, input int sz, input logic [31:0] d);
    int  hit_i, rel, off, ch, sl;
    bit  e_sz, e_map, e_fwd;
    string tag;
    req_valid = 1'b1; req_write = w; req_addr = AW'(a);
    req_size = 3'(sz); req_wdata = d;
    tgt_rdata = 32'h5A00_0000 ^ (a * 32'h0001_0203);
    @(negedge clk);
    req_valid = 1'b0;
    vectors++;
    e_sz = 0; e_map = 0; e_fwd = 0; off = 0; ch = 0; sl = 0; hit_i = -1;
    if (!(sz == 1 || sz == 2 || sz == 4)) begin
      e_sz = 1; tag = "R2";
    end else if (!io_en) begin
      tag = "R3";
    end else begin
      for (int i = 4; i >= 0; i--)
        if (a >= int'(rgn_base[i]) && a < int'(rgn_base[i]) + int'(rgn_len[i])) hit_i = i;
      if (hit_i < 0) begin
        e_map = 1; tag = "R4";
      end else begin
        rel = a - int'(rgn_base[hit_i]);
        case (hit_i)
          0: begin off = rel >> SH; tag = "R5"; end
          1: begin off = (rel + CADD) % 256; tag = "R6"; end
          2: begin off = rel; tag = "R5"; end
          3: begin off = rel; tag = "R6"; end
          default: begin
            ch = (rel >= CHB) ? 1 : 0;
            off = (rel >= CHB) ? rel - CHB : rel;
            tag = "R7";
          end
        endcase
        if (hit_i < 4) begin
          ch = hit_i / 2;
          if (w && (hit_i % 2 == 0) && off == 6) begin
            msel[ch] = d[4]; tag = "R9";
          end
          sl = msel[ch];
          if (dev_present[ch*2+sl]) e_fwd = 1;
          else tag = "R10";
        end else begin
          if (w && !bm_en) tag = "R8";
          else e_fwd = 1;
        end
      end
    end
    chk("R1", "done", 32'(done), 32'd1);
    chk(tag, "err_size", 32'(err_size), 32'(e_sz));
    chk(tag, "err_map", 32'(err_map), 32'(e_map));
    chk(tag, "fwd_valid", 32'(fwd_valid), 32'(e_fwd));
    if (e_fwd) begin
      chk(tag, "region", 32'(fwd_region), 32'(hit_i));
      chk(tag, "chan", 32'(fwd_chan), 32'(ch));
      chk(tag, "slave", 32'(fwd_slave), 32'(sl));
      chk(tag, "offset", 32'(fwd_offset), 32'(off));
      chk(tag, "write", 32'(fwd_write), 32'(w));
      chk(tag, "size", 32'(fwd_size), 32'(sz));
      if (w) chk(tag, "wdata", fwd_wdata, d);
    end
    chk("R11", "rd_data", rd_data, (e_fwd && !w) ? tgt_rdata : 32'd0);
  endtask

  function automatic int pick_size(input int a);
    case (a % 4)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return ((a / 4) % 2 == 1) ? 3 : 0;
    endcase
  endfunction

  task automatic set_map();
    rgn_base[0] = 16'h0010; rgn_len[0] = 16'd16;
    rgn_base[1] = 16'h0020; rgn_len[1] = 16'd4;
    rgn_base[2] = 16'h0030; rgn_len[2] = 16'd8;
    rgn_base[3] = 16'h0038; rgn_len[3] = 16'd4;
    rgn_base[4] = 16'h0040; rgn_len[4] = 16'd16;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_en = 1'b1; bm_en = 1'b1; dev_present = 4'hF;
    req_valid = 1'b0; req_write = 1'b0; req_size = 3'd1; req_addr = '0;
    req_wdata = '0; tgt_rdata = '0;
    set_map();
    msel[0] = 0; msel[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: quiet outputs (R1)
    vectors++;
    chk("R1", "reset done", 32'(done), 32'd0);
    chk("R1", "reset fwd_valid", 32'(fwd_valid), 32'd0);
    chk("R11", "reset rd_data", rd_data, 32'd0);
    // reset selection is master on both channels (R9)
    dev_present = 4'b0101;
    apply(0, 16'h0010, 1, 0);
    apply(0, 16'h0030, 1, 0);
    dev_present = 4'hF;

    // read sweep with mixed sizes
    for (int a = 0; a < 16'h60; a++) apply(0, a, pick_size(a), 0);
    // write sweep, bit 4 of data varies, DMA enable toggles
    for (int a = 0; a < 16'h60; a++) begin
      bm_en = ((a / 3) % 2 == 0);
      apply(1, a, pick_size(a + 1), (a * 32'h1D) ^ (a << 2));
    end
    bm_en = 1'b1;
    // select write and presence check on the same access, all presence patterns
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 4; k++) begin
        dev_present = 4'(p);
        apply(1, 16'h001C, 1, (k % 2 == 1) ? 32'h10 : 32'h0);
        apply(1, 16'h0036, 1, (k / 2 == 1) ? 32'hF0 : 32'hEF);
        apply(0, 16'h0011, 2, 0);
        apply(1, 16'h0021, 1, 32'hA5);
        apply(0, 16'h0033, 4, 0);
        apply(0, 16'h003A, 1, 0);
        apply(0, 16'h0042, 2, 0);
        apply(1, 16'h004B, 4, 32'hCAFE_0001);
      end
    end
    dev_present = 4'hF;
    // I/O disabled: no effect, selection kept
    io_en = 1'b0;
    for (int a = 16'h08; a < 16'h58; a++) apply(1, a, pick_size(a), 32'h10);
    io_en = 1'b1;
    apply(0, 16'h0012, 1, 0);
    apply(0, 16'h0034, 1, 0);
    // overlapping windows: lower region code wins
    rgn_base[2] = 16'h0018;
    for (int a = 16'h10; a < 16'h28; a++) apply(1, a, 1, (a % 2 == 1) ? 32'h10 : 32'h0);
    set_map();
    // small DMA window boundary around the channel split
    for (int a = 16'h3E; a < 16'h52; a++) apply(0, a, 4, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule